// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream, one bit per clock, and flags each point where the three most recently accepted bits, oldest first, read either 1,1,0 or 1,0,1. A bit is accepted only in a cycle where the valid qualifier is high. Both patterns are tracked by one small state machine that remembers only the history the patterns need. A match may share bits with the match before it, so a run such as 1,1,0,1 produces two flags.

In the default variant the flag is combinational. It rises in the same cycle that the completing bit is presented. A parameter selects a registered variant instead, in which the flag comes from a flip-flop and appears one clock later. A synchronous active-high reset clears the history, so new matches can only form from bits that arrive after the reset.

Top module: `seqdet_dual`

## Requirements
- R1: With `REG_OUT`=0, `z_out` is 1 in any cycle where `valid_in` is 1, `x_in` is 0, and the two previously accepted bits, oldest first, were 1 and 1. A bit value of 1 on `x_in` means a one.
- R2: With `REG_OUT`=0, `z_out` is 1 in any cycle where `valid_in` is 1, `x_in` is 1, and the two previously accepted bits, oldest first, were 1 and 0.
- R3: With `REG_OUT`=0, any other three-bit history (000, 001, 010, 011, 100, 111) gives `z_out`=0.
- R4: Matches overlap. The bits of one match count toward the next, so 1,1,0,1 flags on its third and fourth bits, and 1,0,1,0,1 flags on its third and fifth bits.
- R5: `z_out` stays 0 until at least three bits have been accepted since the end of reset.
- R6: While `rst` is high, `z_out` is 0. After reset the history is empty, so bits accepted before the reset never take part in a match.
- R7: In a cycle where `valid_in` is 0, `x_in` is ignored, the remembered history is unchanged, and the combinational `z_out` is 0.
- R8: With `REG_OUT`=1, `z_out` equals the value the `REG_OUT`=0 variant would show for the same inputs one clock earlier. It is 0 after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | High when `x_in` carries a bit to accept |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Match flag for either pattern |

## Verification
In the combinational variant, each flag is due in the same cycle that its completing bit is driven. The bench drives each bit shortly after a falling edge and samples `z_out` one nanosecond later, before the rising edge that accepts the bit. The registered variant is instantiated next to it on the same inputs. At each of those same sample points, its output is compared with the combinational expectation from the previous bit slot, which reflects the single register on its path. Reset and idle-cycle checks are taken at the same sample point, so every result is read while the inputs that produced it are stable.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   // History classes of the minimized detector. The empty class also
   // stands for "last bit was 0 with no useful prefix".
   typedef enum logic [1:0] {
      H_EMPTY   = 2'b00,
      H_ONE     = 2'b01,
      H_ONEONE  = 2'b11,
      H_ONEZERO = 2'b10
   } hist_e;

   localparam int unsigned PAT_LEN = 3;
   localparam logic [PAT_LEN-1:0] PAT_A = 3'b110;
   localparam logic [PAT_LEN-1:0] PAT_B = 3'b101;

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
   import seqdet_pkg::*;
(
   input  hist_e cur_st,
   input  logic  valid_in,
   input  logic  bit_in,
   output hist_e nxt_st,
   output logic  hit
);

   always_comb begin
      nxt_st = cur_st;
      hit    = 1'b0;
      if (valid_in) begin
         unique case (cur_st)
            H_EMPTY: begin
               nxt_st = bit_in ? H_ONE : H_EMPTY;
            end
            H_ONE: begin
               nxt_st = bit_in ? H_ONEONE : H_ONEZERO;
            end
            H_ONEONE: begin
               nxt_st = bit_in ? H_ONEONE : H_ONEZERO;
               hit    = ~bit_in;
            end
            H_ONEZERO: begin
               nxt_st = bit_in ? H_ONE : H_EMPTY;
               hit    = bit_in;
            end
            default: begin
               nxt_st = H_EMPTY;
            end
         endcase
      end
   end

endmodule

// File: rtl/seqdet_hist_reg.sv
module seqdet_hist_reg
   import seqdet_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  hist_e d_st,
   output hist_e q_st
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_st <= H_EMPTY;
      end else begin
         q_st <= d_st;
      end
   end

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
   import seqdet_pkg::*;
#(
   parameter int unsigned REG_OUT = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic valid_in,
   input  logic x_in,
   output logic z_out
);

   localparam bit USE_FLOP = (REG_OUT == 1);

   if (REG_OUT > 1) begin : g_bad_param
      $error("seqdet_dual: REG_OUT must be 0 or 1");
   end

   hist_e hist_q;
   hist_e hist_d;
   logic  hit_c;

   seqdet_next u_next (
      .cur_st   (hist_q),
      .valid_in (valid_in),
      .bit_in   (x_in),
      .nxt_st   (hist_d),
      .hit      (hit_c)
   );

   seqdet_hist_reg u_hist (
      .clk  (clk),
      .rst  (rst),
      .d_st (hist_d),
      .q_st (hist_q)
   );

   if (USE_FLOP) begin : g_reg_out
      logic z_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            z_q <= 1'b0;
         end else begin
            z_q <= hit_c;
         end
      end
      assign z_out = z_q;
   end else begin : g_comb_out
      assign z_out = hit_c & ~rst;
   end

endmodule

// File: rtl/seqdet_dual_chk.sv
module seqdet_dual_chk #(
   parameter int unsigned REG_OUT = 0
)(
   input logic       clk,
   input logic       rst,
   input logic       valid_in,
   input logic       x_in,
   input logic       z_out,
   input logic [1:0] hist
);

   // Independent reference: raw bit history and accepted-bit count.
   logic [1:0] ref_bits;
   logic [1:0] ref_cnt;
   logic       ref_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_bits <= 2'b00;
         ref_cnt  <= 2'd0;
      end else if (valid_in) begin
         ref_bits <= {ref_bits[0], x_in};
         if (ref_cnt != 2'd2) ref_cnt <= ref_cnt + 2'd1;
      end
   end

   assign ref_hit = valid_in && !rst && (ref_cnt == 2'd2) &&
                    (({ref_bits, x_in} == 3'b110) || ({ref_bits, x_in} == 3'b101));

   assert_hit110_R1: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 0 && valid_in && ref_cnt == 2'd2 && ref_bits == 2'b11 && !x_in) |-> z_out);

   assert_hit101_R2: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 0 && valid_in && ref_cnt == 2'd2 && ref_bits == 2'b10 && x_in) |-> z_out);

   assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 0 && !ref_hit) |-> !z_out);

   assert_overlap_R4: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 0 && ref_hit && x_in) |=> (valid_in |-> !z_out));

   assert_startup_R5: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 0 && ref_cnt != 2'd2) |-> !z_out);

   assert_reset_R6: assert property (@(posedge clk)
      rst |=> (hist == 2'b00 && !z_out));

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(hist));

   assert_delay_hi_R8: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 1 && ref_hit) |=> z_out);

   assert_delay_lo_R8: assert property (@(posedge clk) disable iff (rst)
      (REG_OUT == 1 && !ref_hit) |=> !z_out);

endmodule

bind seqdet_dual seqdet_dual_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .valid_in (valid_in),
   .x_in     (x_in),
   .z_out    (z_out),
   .hist     (hist_q)
);

// File: tb/seqdet_dual_tb.sv
`timescale 1ns/1ps
module seqdet_dual_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1;
   logic valid = 1'b0;
   logic x = 1'b0;
   logic z_m;
   logic z_r;

   seqdet_dual #(.REG_OUT(0)) u_dut (
      .clk(clk), .rst(rst), .valid_in(valid), .x_in(x), .z_out(z_m));

   seqdet_dual #(.REG_OUT(1)) u_dut_reg (
      .clk(clk), .rst(rst), .valid_in(valid), .x_in(x), .z_out(z_r));

   int   total = 0;
   int   bad = 0;
   int   cnt = 0;
   logic [1:0] h = 2'b00;
   logic e_prev = 1'b0;
   bit   done = 1'b0;

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: z=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // One bit slot; tag "" picks the requirement from the model.
   task automatic step(string tag, logic v, logic b);
      logic e;
      string t;
      @(negedge clk);
      valid = v;
      x = b;
      #1;
      e = v && (cnt >= 2) && (({h, b} == 3'b110) || ({h, b} == 3'b101));
      if (tag != "") t = tag;
      else if (!v) t = "R7";
      else if (cnt < 2) t = "R5";
      else if ({h, b} == 3'b110) t = "R1";
      else if ({h, b} == 3'b101) t = "R2";
      else t = "R3";
      chk(t, z_m, e);
      chk("R8", z_r, e_prev);
      e_prev = e;
      if (v) begin
         h = {h[0], b};
         if (cnt < 2) cnt++;
      end
   endtask

   task automatic do_reset(logic v, logic b);
      @(negedge clk);
      rst = 1'b1;
      valid = v;
      x = b;
      #1;
      chk("R6", z_m, 1'b0);
      @(negedge clk);
      #1;
      chk("R6", z_m, 1'b0);
      chk("R6", z_r, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      valid = 1'b0;
      x = 1'b0;
      #1;
      chk("R6", z_m, 1'b0);
      chk("R6", z_r, 1'b0);
      h = 2'b00;
      cnt = 0;
      e_prev = 1'b0;
   endtask

   task automatic t_stream();
      logic [14:0] s = 15'b011011001011010;
      do_reset(1'b0, 1'b0);
      for (int i = 14; i >= 0; i--) step("", 1'b1, s[i]);
   endtask

   task automatic t_all_patterns();
      for (int p = 0; p < 8; p++) begin
         logic [2:0] pv = 3'(p);
         do_reset(1'b0, 1'b0);
         for (int i = 2; i >= 0; i--) step("", 1'b1, pv[i]);
      end
   endtask

   task automatic t_overlap_R4();
      logic [7:0] s = 8'b11010110;
      do_reset(1'b0, 1'b0);
      for (int i = 7; i >= 0; i--) step("R4", 1'b1, s[i]);
      do_reset(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step("R4", 1'b1, (i % 2) == 0);
   endtask

   task automatic t_startup_R5();
      do_reset(1'b0, 1'b0);
      step("R5", 1'b1, 1'b1);
      step("R5", 1'b0, 1'b0);
      step("R5", 1'b1, 1'b0);
      step("R5", 1'b0, 1'b1);
      step("", 1'b1, 1'b1);
   endtask

   task automatic t_valid_hold_R7();
      do_reset(1'b0, 1'b0);
      step("", 1'b1, 1'b1);
      step("", 1'b1, 1'b1);
      step("R7", 1'b0, 1'b0);
      step("R7", 1'b0, 1'b1);
      step("R7", 1'b0, 1'b0);
      step("R7", 1'b1, 1'b0);
      step("R7", 1'b0, 1'b0);
      step("R7", 1'b0, 1'b0);
      step("R7", 1'b1, 1'b1);
   endtask

   task automatic t_reset_mid_R6();
      do_reset(1'b0, 1'b0);
      step("", 1'b1, 1'b1);
      step("", 1'b1, 1'b1);
      do_reset(1'b1, 1'b0);
      step("R6", 1'b1, 1'b0);
      step("R6", 1'b1, 1'b1);
      step("R6", 1'b1, 1'b0);
   endtask

   initial begin
      t_stream();
      t_all_patterns();
      t_overlap_R4();
      t_startup_R5();
      t_valid_hold_R7();
      t_reset_mid_R6();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule